// File: doc/BRIEF.md
# DMA Interrupt Status and Transfer Accounting Registers

This block is the interrupt and accounting register set of a single-channel memory-copy DMA engine. The data mover is outside the block; it reports what happens through one-cycle event pulses: transfer finished, bus errors on data reads and writes, descriptor fetch errors on either side, a destination descriptor retired, a source descriptor retired, and a byte amount moved. The block latches each event into a sticky status register and drives a single interrupt line whenever a latched event is not masked.

Software reaches the block through a simple 32-bit register bus with a one-cycle write strobe and a one-cycle read strobe. Write data and address are sampled on the strobe edge; read data is registered and appears on the cycle that follows the read strobe. Masking is changed only through two set-only registers: one that unmasks the sources written as 1 and one that masks them. Two completion counters count retired descriptors per side and clear when read, and a running byte total can be reloaded by software. Each counter reports its own overflow through a dedicated status bit.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0xFFF (every source masked), both completion counters and the byte total read 0, and `irq` is 0.
- R2: An event pulse sets its status bit on the next clock edge, and the bit stays set until cleared: bit 10 transfer finished, bit 9 data-write bus error, bit 8 data-read bus error, bit 7 destination descriptor fetch error, bit 6 source descriptor fetch error, bit 2 destination descriptor retired. Bits 1 and 11 always read 0.
- R3: Writing the status register (offset 0x100) clears each bit written as 1 and leaves the others; when an event and a clearing write hit the same bit in one cycle, the bit stays set.
- R4: Writing offset 0x108 clears the mask bits written as 1; writing offset 0x10C sets the mask bits written as 1; the mask reads back at offset 0x104. The status register shows latched events whether masked or not.
- R5: `irq` is a register that is 1 exactly when, on the previous clock edge, some status bit was set while its mask bit was 0.
- R6: The source completion counter (offset 0x190) increments on each source-retired pulse and the destination completion counter (offset 0x194) on each destination-retired pulse. A read returns the count and leaves it at 0, or at 1 when a pulse for that counter arrives in the same cycle as the read.
- R7: A completion counter at its maximum value (2^CNT_W - 1) that receives a pulse holds that value and sets its count error bit: bit 4 for source, bit 5 for destination.
- R8: The byte total (offset 0x188) adds `byte_amt` on each cycle with `byte_vld`, wrapping modulo 2^BYTE_W; a wrap sets status bit 3. A write to 0x188 loads the written value (0 clears it) and takes precedence over an add in the same cycle. Reads do not change it.
- R9: A read or write at any offset outside {0x100, 0x104, 0x108, 0x10C, 0x188, 0x190, 0x194} sets status bit 0, returns 0 for a read, and changes no mask, counter or other status bit.
- R10: Read data appears on `reg_rdata` the cycle after the read strobe; offsets 0x108 and 0x10C read as 0, and writes to the read-only offsets 0x104, 0x190 and 0x194 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data, valid the cycle after `reg_rd` |
| evt_xfer_done | input | 1 | Transfer finished pulse |
| evt_wr_bus_err | input | 1 | Data-write bus error pulse |
| evt_rd_bus_err | input | 1 | Data-read bus error pulse |
| evt_dst_fetch_err | input | 1 | Destination descriptor fetch error pulse |
| evt_src_fetch_err | input | 1 | Source descriptor fetch error pulse |
| evt_dst_retire | input | 1 | Destination descriptor retired pulse |
| evt_src_retire | input | 1 | Source descriptor retired pulse |
| byte_vld | input | 1 | Byte amount valid |
| byte_amt | input | INC_W | Bytes moved this cycle |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions watch, on every cycle, the rules that link a cycle to the next: an event beats a clearing write, a fully masked register keeps the interrupt low, any unmasked pending bit raises it, a read of the source counter empties it, a saturated counter holds and flags, and an unmapped read returns zero while flagging bit 0. Only the bench scenarios can show the read-back values that come from longer histories: the exact bit positions of each event, mask values after sequences of enable and disable writes, counts after several pulses, the wrap of the byte total and its reload, and that writes to read-only or unmapped offsets leave every register as it was.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int STS_W = 12;

  // Register byte offsets
  localparam int unsigned OFS_STATUS  = 32'h100;
  localparam int unsigned OFS_MASK    = 32'h104;
  localparam int unsigned OFS_UNMASK  = 32'h108;
  localparam int unsigned OFS_SETMASK = 32'h10C;
  localparam int unsigned OFS_BYTES   = 32'h188;
  localparam int unsigned OFS_SCNT    = 32'h190;
  localparam int unsigned OFS_DCNT    = 32'h194;

  // Status bit positions
  localparam int B_XFER_DONE  = 10;
  localparam int B_WR_BUS     = 9;
  localparam int B_RD_BUS     = 8;
  localparam int B_DST_FETCH  = 7;
  localparam int B_SRC_FETCH  = 6;
  localparam int B_DCNT_ERR   = 5;
  localparam int B_SCNT_ERR   = 4;
  localparam int B_BYTE_WRAP  = 3;
  localparam int B_DST_RETIRE = 2;
  localparam int B_BAD_ACCESS = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_UNMASK,
    SEL_SETMASK,
    SEL_BYTES,
    SEL_SCNT,
    SEL_DCNT
  } reg_sel_e;

endpackage

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_set,
  input  logic         clr_we,
  input  logic         unmask_we,
  input  logic         setmask_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);

  logic [W-1:0] clr_bits;

  assign clr_bits = clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      // a new event outranks a clear of the same bit
      status <= evt_set | (status & ~clr_bits);
      if (unmask_we)
        mask <= mask & ~wbits;
      else if (setmask_we)
        mask <= mask | wbits;
      irq <= |(status & ~mask);
    end
  end

endmodule

// File: rtl/retire_counter.sv
module retire_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] count,
  output logic             sat_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign sat_hit = inc && !rd_clr && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (rd_clr) begin
      count <= inc ? CNT_W'(1) : '0;
    end else if (inc && (count != CNT_MAX)) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/byte_total.sv
module byte_total #(
  parameter int BYTE_W = 32,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_vld,
  input  logic [INC_W-1:0]  add_amt,
  input  logic              ld_we,
  input  logic [BYTE_W-1:0] ld_val,
  output logic [BYTE_W-1:0] total,
  output logic              wrap_hit
);

  localparam int EXT_W = BYTE_W + 1;

  logic [EXT_W-1:0] sum;

  assign sum      = {1'b0, total} + {{(EXT_W-INC_W){1'b0}}, add_amt};
  assign wrap_hit = add_vld && !ld_we && sum[BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      total <= '0;
    end else if (ld_we) begin
      total <= ld_val;
    end else if (add_vld) begin
      total <= sum[BYTE_W-1:0];
    end
  end

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 32,
  parameter int INC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_xfer_done,
  input  logic              evt_wr_bus_err,
  input  logic              evt_rd_bus_err,
  input  logic              evt_dst_fetch_err,
  input  logic              evt_src_fetch_err,
  input  logic              evt_dst_retire,
  input  logic              evt_src_retire,
  input  logic              byte_vld,
  input  logic [INC_W-1:0]  byte_amt,
  output logic              irq
);

  localparam int NCNT = 2;  // index 0 source side, 1 destination side

  reg_sel_e          sel;
  logic [STS_W-1:0]  evt_set;
  logic [STS_W-1:0]  sts_q;
  logic [STS_W-1:0]  msk_q;
  logic [NCNT-1:0]   cnt_inc;
  logic [NCNT-1:0]   cnt_clr;
  logic [NCNT-1:0]   cnt_sat;
  logic [CNT_W-1:0]  cnt_val [NCNT];
  logic [CNT_W-1:0]  src_cnt;
  logic [BYTE_W-1:0] bytes_q;
  logic              bytes_wrap;
  logic              bad_access;

  // address decode
  always_comb begin
    case (reg_addr)
      ADDR_W'(OFS_STATUS):  sel = SEL_STATUS;
      ADDR_W'(OFS_MASK):    sel = SEL_MASK;
      ADDR_W'(OFS_UNMASK):  sel = SEL_UNMASK;
      ADDR_W'(OFS_SETMASK): sel = SEL_SETMASK;
      ADDR_W'(OFS_BYTES):   sel = SEL_BYTES;
      ADDR_W'(OFS_SCNT):    sel = SEL_SCNT;
      ADDR_W'(OFS_DCNT):    sel = SEL_DCNT;
      default:              sel = SEL_NONE;
    endcase
  end

  assign bad_access = (reg_rd || reg_wr) && (sel == SEL_NONE);

  // completion counters
  assign cnt_inc = {evt_dst_retire, evt_src_retire};
  assign cnt_clr = {reg_rd && (sel == SEL_DCNT), reg_rd && (sel == SEL_SCNT)};

  generate
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      retire_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc    (cnt_inc[g]),
        .rd_clr (cnt_clr[g]),
        .count  (cnt_val[g]),
        .sat_hit(cnt_sat[g])
      );
    end
  endgenerate

  assign src_cnt = cnt_val[0];

  byte_total #(.BYTE_W(BYTE_W), .INC_W(INC_W)) u_bytes (
    .clk     (clk),
    .rst     (rst),
    .add_vld (byte_vld),
    .add_amt (byte_amt),
    .ld_we   (reg_wr && (sel == SEL_BYTES)),
    .ld_val  (reg_wdata[BYTE_W-1:0]),
    .total   (bytes_q),
    .wrap_hit(bytes_wrap)
  );

  // event vector, placed at the fixed status positions
  always_comb begin
    evt_set               = '0;
    evt_set[B_XFER_DONE]  = evt_xfer_done;
    evt_set[B_WR_BUS]     = evt_wr_bus_err;
    evt_set[B_RD_BUS]     = evt_rd_bus_err;
    evt_set[B_DST_FETCH]  = evt_dst_fetch_err;
    evt_set[B_SRC_FETCH]  = evt_src_fetch_err;
    evt_set[B_DCNT_ERR]   = cnt_sat[1];
    evt_set[B_SCNT_ERR]   = cnt_sat[0];
    evt_set[B_BYTE_WRAP]  = bytes_wrap;
    evt_set[B_DST_RETIRE] = evt_dst_retire;
    evt_set[B_BAD_ACCESS] = bad_access;
  end

  irq_status_unit #(.W(STS_W)) u_sts (
    .clk       (clk),
    .rst       (rst),
    .evt_set   (evt_set),
    .clr_we    (reg_wr && (sel == SEL_STATUS)),
    .unmask_we (reg_wr && (sel == SEL_UNMASK)),
    .setmask_we(reg_wr && (sel == SEL_SETMASK)),
    .wbits     (reg_wdata[STS_W-1:0]),
    .status    (sts_q),
    .mask      (msk_q),
    .irq       (irq)
  );

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (sel)
        SEL_STATUS: reg_rdata <= DATA_W'(sts_q);
        SEL_MASK:   reg_rdata <= DATA_W'(msk_q);
        SEL_BYTES:  reg_rdata <= DATA_W'(bytes_q);
        SEL_SCNT:   reg_rdata <= DATA_W'(cnt_val[0]);
        SEL_DCNT:   reg_rdata <= DATA_W'(cnt_val[1]);
        default:    reg_rdata <= '0;
      endcase
    end else begin
      reg_rdata <= '0;
    end
  end

endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              evt_xfer_done,
  input logic              evt_src_retire,
  input logic              irq,
  input logic [STS_W-1:0]  status,
  input logic [STS_W-1:0]  mask,
  input logic [CNT_W-1:0]  src_cnt
);

  logic mapped;
  logic rd_scnt;

  assign mapped = (reg_addr == ADDR_W'(OFS_STATUS))  || (reg_addr == ADDR_W'(OFS_MASK)) ||
                  (reg_addr == ADDR_W'(OFS_UNMASK))  || (reg_addr == ADDR_W'(OFS_SETMASK)) ||
                  (reg_addr == ADDR_W'(OFS_BYTES))   || (reg_addr == ADDR_W'(OFS_SCNT)) ||
                  (reg_addr == ADDR_W'(OFS_DCNT));
  assign rd_scnt = reg_rd && (reg_addr == ADDR_W'(OFS_SCNT));

  assert_event_wins_R3: assert property (@(posedge clk) disable iff (rst)
    evt_xfer_done |=> status[B_XFER_DONE]);

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> !irq);

  assert_pending_raises_R5: assert property (@(posedge clk) disable iff (rst)
    (|(status & ~mask)) |=> irq);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !mapped) |=> (reg_rdata == '0) && status[B_BAD_ACCESS]);

  assert_read_empties_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_scnt && !evt_src_retire) |=> (src_cnt == '0));

  assert_sat_holds_R7: assert property (@(posedge clk) disable iff (rst)
    ((&src_cnt) && evt_src_retire && !rd_scnt) |=> (&src_cnt) && status[B_SCNT_ERR]);

endmodule

bind dma_irq_regs dma_irq_regs_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .reg_rdata     (reg_rdata),
  .evt_xfer_done (evt_xfer_done),
  .evt_src_retire(evt_src_retire),
  .irq           (irq),
  .status        (sts_q),
  .mask          (msk_q),
  .src_cnt       (src_cnt)
);

// File: tb/sim_dma_irq_regs.sv
`timescale 1ns/1ps
module sim_dma_irq_regs;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int BYTE_W = 16;
  localparam int INC_W  = 16;

  localparam logic [11:0] A_STS  = 12'h100;
  localparam logic [11:0] A_MSK  = 12'h104;
  localparam logic [11:0] A_UNM  = 12'h108;
  localparam logic [11:0] A_SETM = 12'h10C;
  localparam logic [11:0] A_BYT  = 12'h188;
  localparam logic [11:0] A_SCNT = 12'h190;
  localparam logic [11:0] A_DCNT = 12'h194;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              evt_xfer_done = 1'b0;
  logic              evt_wr_bus_err = 1'b0;
  logic              evt_rd_bus_err = 1'b0;
  logic              evt_dst_fetch_err = 1'b0;
  logic              evt_src_fetch_err = 1'b0;
  logic              evt_dst_retire = 1'b0;
  logic              evt_src_retire = 1'b0;
  logic              byte_vld = 1'b0;
  logic [INC_W-1:0]  byte_amt = '0;
  logic              irq;

  int tests = 0;
  int fails = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              rd_seen = 1'b0;

  always #2 clk = ~clk;

  dma_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                 .BYTE_W(BYTE_W), .INC_W(INC_W)) u0 (.*);

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                       input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL scoreboard: unexpected read data 0x%0h", reg_rdata);
      end else begin
        check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // bits: 0 xfer_done,1 wr_bus,2 rd_bus,3 dst_fetch,4 src_fetch,5 dst_retire,6 src_retire
  task automatic pulse(input logic [6:0] b);
    @(negedge clk);
    {evt_src_retire, evt_dst_retire, evt_src_fetch_err, evt_dst_fetch_err,
     evt_rd_bus_err, evt_wr_bus_err, evt_xfer_done} = b;
    @(negedge clk);
    {evt_src_retire, evt_dst_retire, evt_src_fetch_err, evt_dst_fetch_err,
     evt_rd_bus_err, evt_wr_bus_err, evt_xfer_done} = '0;
  endtask

  task automatic add_bytes(input logic [INC_W-1:0] n);
    @(negedge clk); byte_vld = 1'b1; byte_amt = n;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(32'(irq), 0, "R1 irq after reset");
    rd(A_STS, 32'h000, "R1 status reset");
    rd(A_MSK, 32'hFFF, "R1 mask reset");
    rd(A_SCNT, 0, "R1 source count reset");
    rd(A_DCNT, 0, "R1 destination count reset");
    rd(A_BYT, 0, "R1 byte total reset");

    // R2 latch, R4 masked event stays in status, no irq
    pulse(7'b0000001);
    idle(2);
    check(32'(irq), 0, "R4 masked event keeps irq low");
    rd(A_STS, 32'h400, "R2 transfer done bit 10");

    // R4 unmask bit 10, R5 irq one cycle later
    wr(A_UNM, 32'h400);
    idle(1);
    check(32'(irq), 1, "R5 unmasked pending raises irq");
    rd(A_MSK, 32'hBFF, "R4 unmask clears mask bit");

    // R3 write-one-to-clear
    wr(A_STS, 32'h400);
    rd(A_STS, 0, "R3 status cleared");
    check(32'(irq), 0, "R5 irq drops after clear");

    // R3 event wins over clear in the same cycle
    @(negedge clk);
    evt_xfer_done = 1'b1; reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = 32'h400;
    @(negedge clk);
    evt_xfer_done = 1'b0; reg_wr = 1'b0;
    rd(A_STS, 32'h400, "R3 event beats clear");
    wr(A_STS, 32'h400);

    // R2 remaining event positions, still masked except bit 10
    pulse(7'b0111110);
    idle(2);
    check(32'(irq), 0, "R4 other sources stay masked");
    rd(A_STS, 32'h3C4, "R2 bits 9 8 7 6 2");
    wr(A_STS, 32'hFFF);
    wr(A_SETM, 32'hFFF);
    rd(A_MSK, 32'hFFF, "R4 setmask masks all");

    // R6 destination count read-clear
    rd(A_DCNT, 1, "R6 destination count one");
    rd(A_DCNT, 0, "R6 destination count cleared by read");

    // R6 source count
    for (int i = 0; i < 3; i++) pulse(7'b1000000);
    rd(A_SCNT, 3, "R6 source count three");
    rd(A_SCNT, 0, "R6 source count cleared by read");
    pulse(7'b1000000);
    pulse(7'b1000000);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = A_SCNT; evt_src_retire = 1'b1;
    exp_q.push_back(2); tag_q.push_back("R6 read with concurrent pulse");
    @(negedge clk);
    reg_rd = 1'b0; evt_src_retire = 1'b0;
    rd(A_SCNT, 1, "R6 pulse during read counted once");

    // R7 saturation both sides
    for (int i = 0; i < 16; i++) pulse(7'b1000000);
    rd(A_STS, 32'h010, "R7 source count error bit 4");
    rd(A_SCNT, 15, "R7 source count holds max");
    wr(A_STS, 32'hFFF);
    for (int i = 0; i < 16; i++) pulse(7'b0100000);
    rd(A_STS, 32'h024, "R7 destination count error bit 5");
    rd(A_DCNT, 15, "R7 destination count holds max");
    wr(A_STS, 32'hFFF);

    // R8 byte total wrap, reload
    add_bytes(16'h8000);
    add_bytes(16'h8000);
    rd(A_BYT, 0, "R8 byte total wraps");
    rd(A_STS, 32'h008, "R8 wrap sets bit 3");
    add_bytes(16'h0010);
    rd(A_BYT, 32'h10, "R8 byte total adds");
    rd(A_BYT, 32'h10, "R8 read leaves total");
    wr(A_BYT, 0);
    rd(A_BYT, 0, "R8 write zero clears");
    wr(A_BYT, 32'h1234);
    rd(A_BYT, 32'h1234, "R8 write loads value");
    wr(A_STS, 32'hFFF);

    // R9 unmapped access
    wr(12'h200, 32'hFFF);
    rd(A_MSK, 32'hFFF, "R9 unmapped write leaves mask");
    rd(A_STS, 32'h001, "R9 unmapped write sets bit 0");
    rd(12'h050, 0, "R9 unmapped read returns zero");
    rd(A_BYT, 32'h1234, "R9 byte total untouched");

    // R10 write-only reads as zero, read-only ignores writes
    rd(A_UNM, 0, "R10 unmask register reads zero");
    rd(A_SETM, 0, "R10 setmask register reads zero");
    wr(A_MSK, 0);
    rd(A_MSK, 32'hFFF, "R10 mask write ignored");
    pulse(7'b1000000);
    wr(A_SCNT, 32'h7);
    rd(A_SCNT, 1, "R10 count write ignored");
    rd(A_STS, 32'h001, "R10 read-only writes not flagged");

    // R5 bit 0 through irq
    wr(A_UNM, 32'h001);
    idle(1);
    check(32'(irq), 1, "R5 bad access raises irq when unmasked");
    wr(A_SETM, 32'h001);
    idle(1);
    check(32'(irq), 0, "R5 irq drops when remasked");

    idle(4);
    check(32'(exp_q.size()), 0, "scoreboard drained");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule